// File: doc/BRIEF.md
# Radix-4 Signed-Digit to Two's-Complement Converter

This block turns a number written in radix-4 signed digits into an ordinary two's-complement integer. Each digit is a 3-bit two's-complement field in the range -3 to +3. A separate 2-bit overflow digit in the range -1 to +1 sits one position above the most significant digit, as a carry-free signed-digit adder would produce it. The block forms the true sum of every digit times its power of four, then registers that value together with a valid strobe.

The result is placed one clock after the sampling cycle. An error flag comes out in the same cycle as the result. It is raised when the sampled word holds one of the two codes that lie outside the legal digit ranges. Cycles without an input leave the registered result untouched and hold the valid strobe low. The digit count and the result width are parameters. The defaults are four digits and a 16-bit result.

Top module: `sdr4_to_twos`

## Requirements
- R1: With every digit non-negative and the overflow digit zero, the result equals the sum over i of digit i times 4^i. Digit i is the field in bits 3i+2..3i of `digitsIn`, and digit 0 is the least significant.
- R2: A digit with bit 2 set is negative. It is sign-extended to the full result width before it is weighted, so for example the code 3'b101 contributes -3 times 4^i.
- R3: The overflow digit code 2'b01 means +1 and adds 4^N to the result, which is +256 for N = 4.
- R4: The overflow digit code 2'b11 means -1 and subtracts 4^N from the result. The code 2'b00 adds nothing.
- R5: `errOut` is raised in the same cycle as the result whenever any sampled digit holds the code 3'b100. It is low for a sample in which every code is legal. The result value for such a sample is not defined.
- R6: The overflow digit code 2'b10 also raises `errOut` for that sample.
- R7: An input sampled with `inValid` high at a rising edge gives `outValid` high after that edge. In every cycle that had no input, `outValid` is low.
- R8: A synchronous active-high `rst` clears `outValid`, `resultOut` and `errOut` at the next rising edge.
- R9: While `inValid` is low, the digits and the overflow digit are ignored: `resultOut` and `errOut` keep their previous values.
- R10: The result width must be at least 2N+3 bits. With that width, every legal input, the extremes of -511 and +511 for N = 4 included, is exact with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample the digit word this cycle |
| digitsIn | input | 3*NUM_DIGITS | Packed signed digits, digit 0 in the low field |
| carryIn | input | 2 | Overflow digit of weight 4^N |
| outValid | output | 1 | Result register was loaded at the last edge |
| resultOut | output | RES_W | Two's-complement value of the sampled word |
| errOut | output | 1 | Sampled word contained an illegal code |

## Verification
The bench walks every legal four-digit pattern under each of the three overflow values. A converter that concatenated the fields instead of summing them would therefore miss on every word that has a negative digit. The same holds for one that zero-extended digits or weighted the overflow digit at 4^(N-1). Both extremes of the range are covered, so a result that wraps would show up there. The bench also places the illegal code 3'b100 in an upper digit and 2'b10 on the overflow digit on their own. A detector that looked only at digit 0, or that skipped the overflow digit, would leave the flag low. Idle cycles with changing data catch a register that loads without a valid strobe, and a reset in the middle of the run catches a result or flag that survives the reset.

// File: rtl/sdr4_pkg.sv
package sdr4_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic load;   // capture the converted word
    logic clear;  // return result and flag to zero
  } sdr4_strobe_t;

  localparam int DIGIT_W = 3;
  localparam int CARRY_W = 2;

endpackage

// File: rtl/sdr4_ctrl.sv
module sdr4_ctrl
  import sdr4_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output sdr4_strobe_t strobe,
  output logic         outValid
);

  // Reset wins over a load in the same cycle.
  always_comb begin
    strobe.clear = rst;
    strobe.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/sdr4_datapath.sv
module sdr4_datapath
  import sdr4_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int RES_W      = 16
) (
  input  logic                          clk,
  input  sdr4_strobe_t                  strobe,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] digitsIn,
  input  logic [CARRY_W-1:0]            carryIn,
  output logic [RES_W-1:0]              resultOut,
  output logic                          errOut
);

  localparam int NUM_TERMS = NUM_DIGITS + 1;
  localparam int CARRY_SH  = 2 * NUM_DIGITS;

  logic [RES_W-1:0]      termVec [NUM_TERMS];
  logic [NUM_DIGITS-1:0] badDigit;
  logic                  badCarry;
  logic [RES_W-1:0]      sumNext;

  // One weighted, sign-extended term per digit.
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    logic [DIGIT_W-1:0] dig;
    assign dig        = digitsIn[DIGIT_W*g +: DIGIT_W];
    assign termVec[g] = {{(RES_W-DIGIT_W){dig[DIGIT_W-1]}}, dig} << (2*g);
    assign badDigit[g] = (dig == 3'b100);
  end

  // The overflow digit sits one radix-4 position above the top digit.
  assign termVec[NUM_DIGITS] =
    {{(RES_W-CARRY_W){carryIn[CARRY_W-1]}}, carryIn} << CARRY_SH;
  assign badCarry = (carryIn == 2'b10);

  always_comb begin
    sumNext = '0;
    for (int k = 0; k < NUM_TERMS; k++) begin
      sumNext = sumNext + termVec[k];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      resultOut <= '0;
      errOut    <= 1'b0;
    end else if (strobe.load) begin
      resultOut <= sumNext;
      errOut    <= (|badDigit) | badCarry;
    end
  end

endmodule

// File: rtl/sdr4_to_twos.sv
module sdr4_to_twos
  import sdr4_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int RES_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [3*NUM_DIGITS-1:0] digitsIn,
  input  logic [1:0]              carryIn,
  output logic                    outValid,
  output logic [RES_W-1:0]        resultOut,
  output logic                    errOut
);

  sdr4_strobe_t strobe;

  sdr4_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  sdr4_datapath #(
    .NUM_DIGITS (NUM_DIGITS),
    .RES_W      (RES_W)
  ) dp_i (
    .clk       (clk),
    .strobe    (strobe),
    .digitsIn  (digitsIn),
    .carryIn   (carryIn),
    .resultOut (resultOut),
    .errOut    (errOut)
  );

endmodule

// File: rtl/sdr4_to_twos_chk.sv
module sdr4_to_twos_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int RES_W      = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic [3*NUM_DIGITS-1:0] digitsIn,
  input logic [1:0]              carryIn,
  input logic                    outValid,
  input logic [RES_W-1:0]        resultOut,
  input logic                    errOut
);

  int   refSum;
  logic anyBad;

  // Arithmetic reference: digit value times an integer power of four.
  always_comb begin
    refSum = int'($signed(carryIn)) * (4 ** NUM_DIGITS);
    anyBad = (carryIn == 2'b10);
    for (int k = 0; k < NUM_DIGITS; k++) begin
      refSum = refSum + int'($signed(digitsIn[3*k +: 3])) * (4 ** k);
      if (digitsIn[3*k +: 3] == 3'b100) anyBad = 1'b1;
    end
  end

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!outValid && resultOut == '0 && !errOut));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(resultOut) && $stable(errOut)));

  // R5
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && anyBad) |=> errOut);

  // R1
  legal_value_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !anyBad) |=>
      (!errOut && int'($signed(resultOut)) == $past(refSum)));

endmodule

bind sdr4_to_twos sdr4_to_twos_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .RES_W      (RES_W)
) chk_i (.*);

// File: tb/sdr4_to_twos_tb_top.sv
`timescale 1ns/1ps
module sdr4_to_twos_tb_top;

  localparam int ND = 4;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic [3*ND-1:0] digitsIn;
  logic [1:0]    carryIn;
  logic          outValid;
  logic [RW-1:0] resultOut;
  logic          errOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdr4_to_twos #(.NUM_DIGITS(ND), .RES_W(RW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .digitsIn  (digitsIn),
    .carryIn   (carryIn),
    .outValid  (outValid),
    .resultOut (resultOut),
    .errOut    (errOut)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int held;
    rst = 1'b1; inValid = 1'b1; digitsIn = 12'hABC; carryIn = 2'b01;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "outValid", int'(outValid), 0);
    check("R8", "result", int'(resultOut), 0);
    check("R8", "errOut", int'(errOut), 0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);
    check("R7", "outValid idle", int'(outValid), 0);

    // R1 R2 R3 R4: full sweep of legal words
    for (int c = -1; c <= 1; c++)
      for (int a3 = -3; a3 <= 3; a3++)
        for (int a2 = -3; a2 <= 3; a2++)
          for (int a1 = -3; a1 <= 3; a1++)
            for (int a0 = -3; a0 <= 3; a0++) begin
              int    exp;
              string tag;
              exp = a0 + 4*a1 + 16*a2 + 64*a3 + 256*c;
              if (c == 1)       tag = "R3";
              else if (c == -1) tag = "R4";
              else if (a0 < 0 || a1 < 0 || a2 < 0 || a3 < 0) tag = "R2";
              else              tag = "R1";
              inValid  = 1'b1;
              digitsIn = {3'(a3), 3'(a2), 3'(a1), 3'(a0)};
              carryIn  = 2'(c);
              @(negedge clk);
              check(tag, "value", int'($signed(resultOut)), exp);
              check("R5", "errOut legal", int'(errOut), 0);
              if (a0 == 3 && a3 == 3) check("R7", "outValid", int'(outValid), 1);
              if ((a0 == 3 && a1 == 3 && a2 == 3 && a3 == 3 && c == 1) ||
                  (a0 == -3 && a1 == -3 && a2 == -3 && a3 == -3 && c == -1))
                check("R10", "extreme", int'($signed(resultOut)), exp);
            end

    // R9: idle cycles with changing data leave the registers alone
    held = int'(resultOut);
    inValid = 1'b0; digitsIn = {3'b100, 3'b001, 3'b010, 3'b111}; carryIn = 2'b10;
    @(negedge clk);
    check("R7", "outValid idle", int'(outValid), 0);
    digitsIn = 12'h249; carryIn = 2'b11;
    @(negedge clk);
    check("R9", "result held", int'(resultOut), held);
    check("R9", "errOut held", int'(errOut), 0);

    // R5: illegal code in an upper digit
    inValid = 1'b1; digitsIn = {3'b000, 3'b100, 3'b000, 3'b001}; carryIn = 2'b00;
    @(negedge clk);
    check("R5", "errOut digit2", int'(errOut), 1);
    check("R7", "outValid", int'(outValid), 1);
    // R5: illegal code in the top digit
    digitsIn = {3'b100, 3'b000, 3'b000, 3'b000};
    @(negedge clk);
    check("R5", "errOut digit3", int'(errOut), 1);
    // R6: illegal overflow digit alone
    digitsIn = 12'h000; carryIn = 2'b10;
    @(negedge clk);
    check("R6", "errOut carry", int'(errOut), 1);
    // flag drops for a legal word
    digitsIn = {3'b000, 3'b000, 3'b011, 3'b000}; carryIn = 2'b00;
    @(negedge clk);
    check("R5", "errOut cleared", int'(errOut), 0);
    check("R1", "value", int'($signed(resultOut)), 12);

    // R8: reset mid-run after a flagged word
    digitsIn = {3'b100, 3'b010, 3'b000, 3'b000}; carryIn = 2'b01;
    @(negedge clk);
    check("R5", "errOut before reset", int'(errOut), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R8", "outValid", int'(outValid), 0);
    check("R8", "result", int'(resultOut), 0);
    check("R8", "errOut", int'(errOut), 0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule